// File: doc/BRIEF.md
# Serial Engine Run-State Controller

This block owns the operating state of a serial master core. Software requests one of three states through a small register port: reset, run or pause. The block does not switch at once. It lowers a settled flag, waits a fixed settle window that stands in for the crossing between the register clock and the core clock, and then reports the new state with the flag raised again. Software polls the flag before it issues the next request. While the flag is low, further state requests are discarded.

The datapath sees two plain enables. The run enable lets the command sequencer advance. The pause enable holds it in place so that software can refill commands without losing queued data. Neither enable is high while a change is in progress. A latched error interrupt records bus-error events from the protocol engine. Software clears it either by requesting the reset state or by writing the separate software-reset register. A software reset also cancels any change in progress. There is no streaming data at this block's edge, so every pin is a plain level or a single-cycle strobe.

Top module: `run_state_ctrl`

## Requirements
- R1: After reset is released, the reported state is reset (code 0), the settled flag is 1, the interrupt is 0, and both enables are 0.
- R2: With `reg_sel`=0, `reg_rdata` returns the status word: bits [1:0] hold the state code (reset 0, run 1, pause 3), bit 2 holds the settled flag, bit 4 mirrors `master_idle`, and all other bits are 0. With `reg_sel`=1, `reg_rdata` is all zeros.
- R3: A write with `reg_sel`=0 of code 0, 1 or 3 while the flag is 1 is accepted. The flag reads 0 from the next cycle for exactly SETTLE cycles, and the old state code stays visible during that time. The flag then returns to 1 together with the new code. A request for the current state also goes through the full window.
- R4: A write of code 2 has no effect. State, flag and interrupt stay unchanged.
- R5: A state write that arrives while the flag is 0 is dropped. The change already in progress completes with its original target.
- R6: `run_en` is 1 only when the flag is 1 and the state is run. `pause_en` is 1 only when the flag is 1 and the state is pause.
- R7: A cycle with `bus_err` high sets `err_irq` from the next cycle. It stays set until it is cleared.
- R8: An accepted write of the reset code clears `err_irq` from the next cycle. If `bus_err` is high in the same cycle, the interrupt stays set.
- R9: A write with `reg_sel`=1 and bit 0 set acts as a software reset. From the next cycle the state is reset and the flag is 1, even in the middle of a change, and `err_irq` is 0 even if `bus_err` was high in that cycle. The same write with bit 0 clear has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register select: 0 = state register, 1 = software-reset register |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of the selected register |
| master_idle | input | 1 | Bus master generator ready, reported in the status word |
| bus_err | input | 1 | Bus error event from the protocol engine |
| run_en | output | 1 | Datapath may advance |
| pause_en | output | 1 | Datapath held for command refill |
| err_irq | output | 1 | Latched error interrupt |

## Verification
The main function is driven with isolated requests for each legal code, a repeat request for the current state, and the unused code. These tell a real transition apart from one that must leave everything unchanged. Requests are also issued inside the settle window, both legal codes and the unused one. They separate a design that drops late writes from one that retargets or restarts its change. Error events are placed alone, in the same cycle as a reset request, and in the same cycle as a software reset. These expose the priority between setting and clearing the interrupt. A software reset is issued in the middle of a transition and again with its bit clear, to tell an abort from a write that is ignored.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  localparam logic [1:0] CODE_RESET = 2'd0;
  localparam logic [1:0] CODE_RUN   = 2'd1;
  localparam logic [1:0] CODE_SPARE = 2'd2;
  localparam logic [1:0] CODE_PAUSE = 2'd3;

  localparam int BIT_SETTLED = 2;
  localparam int BIT_MIDLE   = 4;
endpackage

// File: rtl/rsc_regif.sv
module rsc_regif #(
  parameter int DATA_W = 32
) (
  input  logic              reg_sel,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [1:0]        cur_state,
  input  logic              cur_valid,
  input  logic              master_idle,
  output logic              state_wr,
  output logic [1:0]        state_code,
  output logic              sreset,
  output logic [DATA_W-1:0] reg_rdata
);
  import rsc_pkg::*;

  assign state_wr   = reg_we & ~reg_sel;
  assign state_code = reg_wdata[1:0];
  assign sreset     = reg_we & reg_sel & reg_wdata[0];

  always_comb begin
    reg_rdata = '0;
    if (!reg_sel) begin
      reg_rdata[1:0]         = cur_state;
      reg_rdata[BIT_SETTLED] = cur_valid;
      reg_rdata[BIT_MIDLE]   = master_idle;
    end
  end
endmodule

// File: rtl/rsc_seq.sv
module rsc_seq #(
  parameter int SETTLE = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sreset,
  input  logic       state_wr,
  input  logic [1:0] state_code,
  output logic [1:0] cur_state,
  output logic       cur_valid,
  output logic       accept
);
  import rsc_pkg::*;

  localparam int CNT_W = $clog2(SETTLE + 1);

  logic [CNT_W-1:0] remain_q;
  logic [1:0]       target_q;

  assign accept = state_wr & cur_valid & (state_code != CODE_SPARE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_state <= CODE_RESET;
      cur_valid <= 1'b1;
      target_q  <= CODE_RESET;
      remain_q  <= '0;
    end else if (sreset) begin
      cur_state <= CODE_RESET;
      cur_valid <= 1'b1;
      target_q  <= CODE_RESET;
      remain_q  <= '0;
    end else if (accept) begin
      cur_valid <= 1'b0;
      target_q  <= state_code;
      remain_q  <= CNT_W'(SETTLE - 1);
    end else if (!cur_valid) begin
      if (remain_q == '0) begin
        cur_state <= target_q;
        cur_valid <= 1'b1;
      end else begin
        remain_q <= remain_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/rsc_irq.sv
module rsc_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic sreset,
  input  logic set_evt,
  input  logic clr_req,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq <= 1'b0;
    else if (sreset)  irq <= 1'b0;
    else if (set_evt) irq <= 1'b1;
    else if (clr_req) irq <= 1'b0;
  end
endmodule

// File: rtl/run_state_ctrl.sv
module run_state_ctrl #(
  parameter int DATA_W = 32,
  parameter int SETTLE = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              master_idle,
  input  logic              bus_err,
  output logic              run_en,
  output logic              pause_en,
  output logic              err_irq
);
  import rsc_pkg::*;

  logic       state_wr, sreset, accept;
  logic [1:0] state_code, cur_state;
  logic       cur_valid;

  rsc_regif #(.DATA_W(DATA_W)) u_regif (
    .reg_sel(reg_sel), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .cur_state(cur_state), .cur_valid(cur_valid), .master_idle(master_idle),
    .state_wr(state_wr), .state_code(state_code), .sreset(sreset),
    .reg_rdata(reg_rdata)
  );

  rsc_seq #(.SETTLE(SETTLE)) u_seq (
    .clk(clk), .rst_n(rst_n), .sreset(sreset), .state_wr(state_wr),
    .state_code(state_code), .cur_state(cur_state), .cur_valid(cur_valid),
    .accept(accept)
  );

  rsc_irq u_irq (
    .clk(clk), .rst_n(rst_n), .sreset(sreset), .set_evt(bus_err),
    .clr_req(accept & (state_code == CODE_RESET)), .irq(err_irq)
  );

  assign run_en   = cur_valid & (cur_state == CODE_RUN);
  assign pause_en = cur_valid & (cur_state == CODE_PAUSE);
endmodule

// File: rtl/run_state_ctrl_chk.sv
module run_state_ctrl_chk #(
  parameter int DATA_W = 32,
  parameter int SETTLE = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_sel,
  input logic              reg_we,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [1:0]        cur_state,
  input logic              cur_valid,
  input logic              bus_err,
  input logic              run_en,
  input logic              pause_en,
  input logic              err_irq
);
  logic sr_w, st_w;
  assign sr_w = reg_we & reg_sel & reg_wdata[0];
  assign st_w = reg_we & ~reg_sel;

  int unsigned low_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          low_cnt <= 0;
    else if (cur_valid)  low_cnt <= 0;
    else                 low_cnt <= low_cnt + 1;
  end

  assert_settle_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    low_cnt <= SETTLE);

  assert_accept_drops_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_w && cur_valid && reg_wdata[1:0] != 2'd2) |=> !cur_valid);

  assert_spare_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_w && cur_valid && reg_wdata[1:0] == 2'd2 && !bus_err)
      |=> ($stable(cur_state) && cur_valid && $stable(err_irq)));

  assert_hold_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cur_valid && !sr_w) |=> ($stable(cur_state) || cur_valid));

  assert_enables_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({run_en, pause_en}) && (!cur_valid -> !(run_en || pause_en)));

  assert_err_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err && !sr_w) |=> err_irq);

  assert_soft_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sr_w |=> (cur_state == 2'd0 && cur_valid && !err_irq));
endmodule

bind run_state_ctrl run_state_ctrl_chk #(.DATA_W(DATA_W), .SETTLE(SETTLE)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .cur_state(cur_state), .cur_valid(cur_valid),
  .bus_err(bus_err), .run_en(run_en), .pause_en(pause_en), .err_irq(err_irq)
);

// File: tb/run_state_ctrl_bench.sv
module run_state_ctrl_bench;
  localparam int DATA_W = 32;
  localparam int SETTLE = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_sel = 1'b0, reg_we = 1'b0, master_idle = 1'b0, bus_err = 1'b0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic run_en, pause_en, err_irq;

  always #10 clk = ~clk;

  run_state_ctrl #(.DATA_W(DATA_W), .SETTLE(SETTLE)) u_run_state_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .master_idle(master_idle),
    .bus_err(bus_err), .run_en(run_en), .pause_en(pause_en), .err_irq(err_irq)
  );

  int vectors = 0;
  int errors  = 0;
  string phase = "R1";

  // behavioural model
  int m_state = 0;
  int m_settled = 1;
  int m_left = 0;
  int m_goal = 0;
  int m_irq = 0;

  task automatic check_bit(string what, logic act, int exp);
    vectors++;
    if (act !== exp[0]) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", phase, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [DATA_W-1:0] exp_rd;
    exp_rd = '0;
    if (!reg_sel) begin
      exp_rd = DATA_W'(m_state) | (DATA_W'(m_settled) << 2) | (DATA_W'(master_idle) << 4);
    end
    vectors++;
    if (reg_rdata !== exp_rd) begin
      errors++;
      $display("FAIL %s/R2 rdata: actual %h expected %h at %0t", phase, reg_rdata, exp_rd, $time);
    end
    check_bit("R6 run_en", run_en, (m_settled == 1 && m_state == 1) ? 1 : 0);
    check_bit("R6 pause_en", pause_en, (m_settled == 1 && m_state == 3) ? 1 : 0);
    check_bit("R7 err_irq", err_irq, m_irq);
  endtask

  task automatic model_step();
    int code;
    code = int'(reg_wdata[1:0]);
    if (reg_we && reg_sel && reg_wdata[0]) begin
      m_state = 0; m_settled = 1; m_left = 0; m_irq = 0;
    end else begin
      if (bus_err) m_irq = 1;
      else if (reg_we && !reg_sel && m_settled == 1 && code == 0) m_irq = 0;
      if (reg_we && !reg_sel && m_settled == 1 && code != 2) begin
        m_goal = code; m_settled = 0; m_left = SETTLE;
      end else if (m_settled == 0) begin
        m_left--;
        if (m_left == 0) begin
          m_state = m_goal; m_settled = 1;
        end
      end
    end
  endtask

  // one clock: compare at the falling edge, apply new inputs, advance the model
  task automatic cyc(input logic sel, input logic we, input int data,
                     input logic err, input logic idle);
    @(negedge clk);
    compare();
    reg_sel = sel; reg_we = we; reg_wdata = DATA_W'(data);
    bus_err = err; master_idle = idle;
    model_step();
  endtask

  task automatic idle_n(int n, logic idl);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 0, 1'b0, idl);
  endtask

  task automatic wr_state(int code, logic err);
    cyc(1'b0, 1'b1, code, err, 1'b1);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    phase = "R1"; idle_n(3, 1'b0);
    phase = "R2"; idle_n(2, 1'b1);
    cyc(1'b1, 1'b0, 0, 1'b0, 1'b1);
    cyc(1'b1, 1'b0, 0, 1'b0, 1'b0);
    phase = "R3"; wr_state(1, 1'b0); idle_n(9, 1'b1);
    wr_state(1, 1'b0); idle_n(8, 1'b1);
    phase = "R5"; wr_state(3, 1'b0); idle_n(2, 1'b1);
    wr_state(0, 1'b0); wr_state(2, 1'b0); wr_state(1, 1'b0); idle_n(6, 1'b1);
    phase = "R4"; wr_state(2, 1'b0); idle_n(3, 1'b1);
    phase = "R7"; cyc(1'b0, 1'b0, 0, 1'b1, 1'b0); idle_n(3, 1'b0);
    wr_state(1, 1'b0); idle_n(8, 1'b1);
    phase = "R8"; wr_state(0, 1'b0); idle_n(8, 1'b1);
    cyc(1'b0, 1'b0, 0, 1'b1, 1'b1); idle_n(1, 1'b1);
    wr_state(0, 1'b1); idle_n(8, 1'b1);
    phase = "R9"; wr_state(3, 1'b0); idle_n(2, 1'b1);
    cyc(1'b1, 1'b1, 1, 1'b0, 1'b1); idle_n(8, 1'b1);
    wr_state(1, 1'b0); idle_n(8, 1'b1);
    cyc(1'b1, 1'b1, 2, 1'b0, 1'b1); idle_n(3, 1'b1);
    cyc(1'b1, 1'b1, 1, 1'b1, 1'b1); idle_n(3, 1'b1);
    phase = "R6"; wr_state(3, 1'b0); idle_n(8, 1'b0);
    wr_state(1, 1'b0); idle_n(8, 1'b1);
    @(negedge clk); compare();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule